// File: doc/BRIEF.md
# E1 Timeslot Zero Framer

This block builds the eight-bit timeslot-zero field of a 2.048 Mbit/s E1 frame that has 32 timeslots and 256 bit clocks per frame. It emits the field as a serial bit stream. The block alternates between two formats on a fixed two-frame cycle.

A sync frame carries the seven-bit alignment pattern after the spare bit. A non-sync frame carries the spare bit, then a forced one, then six user bits. The forced one guarantees that a non-sync frame can never look like the alignment pattern to a receiver.

A frame strobe marks timeslot zero. It is high for eight consecutive bit clocks once per frame. Outside timeslot zero the serial output is either held low or passes through a data input, chosen by a select pin. A registered sync-frame indicator tells downstream logic which format is on the line. Such logic includes a CRC inserter or a line coder.

Top module: `e1_ts0_framer`

## Requirements
- R1: While `rst` is high, on the following edge `ser_out` is 0 and `sync_ind` is 1. The first timeslot zero after reset is a sync frame.
- R2: In a sync frame, bit 1 of timeslot zero is the value of `spare_bit` sampled in the first strobe cycle.
- R3: In a sync frame, bits 2 to 8 are the pattern 0011011, sent most significant bit first (bit 2 = 0, bit 8 = 1).
- R4: In a non-sync frame, bit 1 is the sampled `spare_bit` and bit 2 is always 1.
- R5: In a non-sync frame, bits 3 to 8 are `user_bits[5]` down to `user_bits[0]`, in that order.
- R6: Sync and non-sync frames strictly alternate, one format per strobe.
- R7: `sync_ind` is 1 while a sync frame's timeslot zero is on `ser_out` and 0 during a non-sync one. It is stable for the whole output timeslot. It changes on the second rising edge after the first edge at which the strobe is sampled low.
- R8: Each timeslot bit appears on `ser_out` one clock after the edge at which the strobe cycle carrying it is sampled. Bit 1 follows the edge of the first high strobe cycle.
- R9: `user_bits` are captured when the strobe rises. Changes to them later in the same timeslot have no effect on that timeslot.
- R10: When the strobe is sampled low, `ser_out` on the next cycle is 0 if `pass_en` is 0, or the sampled `pass_data` if `pass_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame strobe, high for the 8 cycles of timeslot zero |
| spare_bit | input | 1 | International spare bit for bit 1 |
| user_bits | input | 6 | User bits for bits 3 to 8 of non-sync frames |
| pass_en | input | 1 | 1: pass `pass_data` outside timeslot zero; 0: send zeros |
| pass_data | input | 1 | Serial data used outside timeslot zero |
| ser_out | output | 1 | Registered serial output |
| sync_ind | output | 1 | Registered sync-frame indicator |

## Verification
The assertions assume a well-formed strobe. It is exactly eight cycles high, frames are far longer than ten cycles, and reset is never applied while the strobe is high. If reset came mid-strobe, the block would see a fresh strobe edge and bit numbering would restart. The bench always drives the strobe from a frame loop with 256 cycles, asserts reset only outside timeslot zero, and changes inputs on falling clock edges. It sweeps every user-bit value over successive frames and toggles the spare bit and the pass-through select. It also restarts the frame cycle with a reset in the middle of a non-sync frame.

// File: rtl/e1ts0_pkg.sv
package e1ts0_pkg;
  // Bits in one timeslot and default alignment pattern (bits 2..8, MSB first)
  localparam int unsigned SLOT_BITS_DEF = 8;
  localparam logic [SLOT_BITS_DEF-2:0] ALIGN_DEF = 7'b0011011;

  function automatic int unsigned idx_width(input int unsigned slot_bits);
    return $clog2(slot_bits + 1);
  endfunction
endpackage

// File: rtl/ts0_strobe_track.sv
module ts0_strobe_track #(
  parameter int unsigned SLOT_BITS = 8,
  localparam int unsigned IDX_W = e1ts0_pkg::idx_width(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  output logic             strobe_rise,
  output logic             strobe_fall,
  output logic [IDX_W-1:0] bit_idx
);
  logic             fsync_q;
  logic [IDX_W-1:0] cnt_q;

  assign strobe_rise = fsync & ~fsync_q;
  assign strobe_fall = ~fsync & fsync_q;
  assign bit_idx     = strobe_rise ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsync_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      fsync_q <= fsync;
      if (strobe_rise)
        cnt_q <= IDX_W'(1);
      else if (fsync && cnt_q < IDX_W'(SLOT_BITS))
        cnt_q <= cnt_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/ts0_frame_phase.sv
module ts0_frame_phase (
  input  logic clk,
  input  logic rst,
  input  logic strobe_fall,
  output logic sync_frame
);
  logic flip_pend;

  // Phase flips one clock after the output timeslot has ended
  always_ff @(posedge clk) begin
    if (rst) begin
      flip_pend  <= 1'b0;
      sync_frame <= 1'b1;
    end else begin
      flip_pend <= strobe_fall;
      if (flip_pend)
        sync_frame <= ~sync_frame;
    end
  end
endmodule

// File: rtl/ts0_bit_mux.sv
module ts0_bit_mux #(
  parameter int unsigned SLOT_BITS = 8,
  parameter logic [SLOT_BITS-2:0] ALIGN_WORD = e1ts0_pkg::ALIGN_DEF,
  localparam int unsigned IDX_W  = e1ts0_pkg::idx_width(SLOT_BITS),
  localparam int unsigned USER_W = SLOT_BITS - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_slot,
  input  logic              strobe_rise,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              sync_frame,
  input  logic              spare_bit,
  input  logic [USER_W-1:0] user_bits,
  input  logic              pass_en,
  input  logic              pass_data,
  output logic              ser_out
);
  logic [USER_W-1:0] user_q;
  logic              slot_bit;
  logic              next_out;
  int                sel;

  always_comb begin
    sel = int'(SLOT_BITS) - 1 - int'(bit_idx);
    if (bit_idx == '0)
      slot_bit = spare_bit;
    else if (int'(bit_idx) >= int'(SLOT_BITS))
      slot_bit = 1'b0;
    else if (sync_frame)
      slot_bit = ALIGN_WORD[sel];
    else if (bit_idx == IDX_W'(1))
      slot_bit = 1'b1;
    else
      slot_bit = user_q[sel];
  end

  assign next_out = in_slot ? slot_bit : (pass_en & pass_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      user_q  <= '0;
      ser_out <= 1'b0;
    end else begin
      if (strobe_rise)
        user_q <= user_bits;
      ser_out <= next_out;
    end
  end
endmodule

// File: rtl/e1_ts0_framer.sv
module e1_ts0_framer #(
  parameter int unsigned SLOT_BITS = e1ts0_pkg::SLOT_BITS_DEF,
  parameter logic [SLOT_BITS-2:0] ALIGN_WORD = e1ts0_pkg::ALIGN_DEF,
  localparam int unsigned IDX_W  = e1ts0_pkg::idx_width(SLOT_BITS),
  localparam int unsigned USER_W = SLOT_BITS - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              spare_bit,
  input  logic [USER_W-1:0] user_bits,
  input  logic              pass_en,
  input  logic              pass_data,
  output logic              ser_out,
  output logic              sync_ind
);
  logic             strobe_rise;
  logic             strobe_fall;
  logic [IDX_W-1:0] bit_idx;
  logic             sync_frame;

  ts0_strobe_track #(.SLOT_BITS(SLOT_BITS)) u_track (
    .clk         (clk),
    .rst         (rst),
    .fsync       (fsync),
    .strobe_rise (strobe_rise),
    .strobe_fall (strobe_fall),
    .bit_idx     (bit_idx)
  );

  ts0_frame_phase u_phase (
    .clk         (clk),
    .rst         (rst),
    .strobe_fall (strobe_fall),
    .sync_frame  (sync_frame)
  );

  ts0_bit_mux #(.SLOT_BITS(SLOT_BITS), .ALIGN_WORD(ALIGN_WORD)) u_mux (
    .clk         (clk),
    .rst         (rst),
    .in_slot     (fsync),
    .strobe_rise (strobe_rise),
    .bit_idx     (bit_idx),
    .sync_frame  (sync_frame),
    .spare_bit   (spare_bit),
    .user_bits   (user_bits),
    .pass_en     (pass_en),
    .pass_data   (pass_data),
    .ser_out     (ser_out)
  );

  assign sync_ind = sync_frame;
endmodule

// File: rtl/e1_ts0_framer_checker.sv
module e1_ts0_framer_checker #(
  parameter int unsigned SLOT_BITS = 8
) (
  input logic clk,
  input logic rst,
  input logic fsync,
  input logic spare_bit,
  input logic pass_en,
  input logic pass_data,
  input logic ser_out,
  input logic sync_ind
);
  localparam int unsigned CW = $clog2(SLOT_BITS + 1);
  logic [CW-1:0] high_cnt;

  // Counts strobe-high cycles seen before the current one
  always_ff @(posedge clk) begin
    if (rst || !fsync) high_cnt <= '0;
    else if (high_cnt < CW'(SLOT_BITS)) high_cnt <= high_cnt + CW'(1);
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> (!ser_out && sync_ind));

  assert_spare_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |=> (ser_out == $past(spare_bit)));

  assert_forced_one_R4: assert property (@(posedge clk) disable iff (rst)
    (fsync && high_cnt == CW'(1) && !sync_ind) |=> ser_out);

  assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(fsync) |=> ##1 (sync_ind != $past(sync_ind)));

  assert_ind_stable_R7: assert property (@(posedge clk) disable iff (rst)
    fsync |=> $stable(sync_ind));

  assert_fill_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!fsync && !pass_en) |=> !ser_out);

  assert_pass_R10: assert property (@(posedge clk) disable iff (rst)
    (!fsync && pass_en) |=> (ser_out == $past(pass_data)));
endmodule

bind e1_ts0_framer e1_ts0_framer_checker #(.SLOT_BITS(SLOT_BITS)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .fsync     (fsync),
  .spare_bit (spare_bit),
  .pass_en   (pass_en),
  .pass_data (pass_data),
  .ser_out   (ser_out),
  .sync_ind  (sync_ind)
);

// File: tb/e1_ts0_framer_tb.sv
`timescale 1ns/1ps
module e1_ts0_framer_tb;
  localparam logic [6:0] AW = 7'b0011011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b0;
  logic       spare_bit = 1'b0;
  logic [5:0] user_bits = '0;
  logic       pass_en = 1'b0;
  logic       pass_data = 1'b0;
  logic       ser_out;
  logic       sync_ind;

  int  n_checks = 0;
  int  n_fail = 0;
  logic ft = 1'b1;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  e1_ts0_framer u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .spare_bit(spare_bit),
    .user_bits(user_bits), .pass_en(pass_en), .pass_data(pass_data),
    .ser_out(ser_out), .sync_ind(sync_ind)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fsync = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset ser_out", ser_out, 1'b0);
    chk("R1 reset sync_ind", sync_ind, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    ft = 1'b1;
  endtask

  // Runs n cycles of a 256-cycle frame; user bits change at cycle 3 (R9)
  task automatic run_frame(input logic pe, input logic sp,
                           input logic [5:0] u0, input int n);
    logic [5:0] u1;
    logic       pd;
    logic       exp_s;
    string      tag;
    u1 = ~u0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      fsync     = (c < 8);
      spare_bit = (c == 0) ? sp : ~sp;
      user_bits = (c < 3) ? u0 : u1;
      pass_en   = pe;
      pd        = logic'(((c * 7) >> 2) & 1);
      pass_data = pd;
      @(posedge clk); #1;
      if (c == 0) begin
        exp_s = sp; tag = ft ? "R2/R8 sync bit1" : "R4/R8 nonsync bit1";
      end else if (c < 8) begin
        if (ft) begin
          exp_s = AW[7-c]; tag = "R3 align bit";
        end else if (c == 1) begin
          exp_s = 1'b1; tag = "R4 forced one";
        end else begin
          exp_s = u0[7-c]; tag = "R5/R9 user bit";
        end
      end else begin
        exp_s = pe & pd; tag = "R10 fill";
      end
      chk(tag, ser_out, exp_s);
      if (c == 0) chk("R6 frame phase", sync_ind, ft);
      chk("R7 indicator", sync_ind, (c >= 9) ? ~ft : ft);
    end
    if (n >= 10) ft = ~ft;
  endtask

  initial begin
    do_reset();
    for (int u = 0; u < 64; u++)
      run_frame(logic'(u[1]), logic'(u[0] ^ u[2]), 6'(u), 256);
    run_frame(1'b1, 1'b0, 6'b101101, 256);
    run_frame(1'b0, 1'b1, 6'b010010, 120);   // non-sync frame cut by reset
    do_reset();
    run_frame(1'b0, 1'b1, 6'b111000, 256);   // R1: sync frame after reset
    run_frame(1'b1, 1'b0, 6'b000111, 256);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule